// File: doc/BRIEF.md
# CPU-to-PCI Host Bridge Address Decoder

This block sits between a CPU bus and the PCI side of a simple host bridge. Each CPU request carries an address, a read/write flag, a byte count (1, 2 or 4) and write data, and is offered with a valid/ready handshake. The block sorts the address into one of four target classes: I/O, configuration, interrupt acknowledge or memory. It rewrites the address into the form that target expects and then issues a single registered downstream request tagged with its class. A request that lands outside every window is not forwarded. It finishes on a short response channel with an error flag set and all-ones read data.

Configuration cycles are selected by a single one-hot address bit. The block converts the position of that bit into a device number. The low part of the I/O window has two mappings, chosen by a mode input that may change at run time. The contiguous mapping takes the low 16 bits of the offset. The sparse mapping gathers address bits from separate 4 KiB pages into a dense port number. The block also contains the interrupt pin swizzle, which folds a device's interrupt pin and slot onto one of two controller lines.

Top module: `hbd_bridge_decode`

## Requirements
- R1: After reset, cpu_ready is 1, and dn_valid, rsp_valid and swz_line are 0.
- R2: Addresses 0x80800000–0x80BFFFFF are configuration cycles, with dn_kind = 1. This range wins over the I/O window. dn_addr[10:0] = cpu_addr[10:0] and dn_addr[14:11] = the device number. The device number is the index (0–10) of the lowest set bit of cpu_addr[21:11], or 11 when none of those bits is set. dn_addr[31:15] = 0.
- R3: When sparse_mode = 0, addresses 0x80000000–0x807FFFFF are I/O with dn_kind = 0, and dn_addr = the low 16 bits of (cpu_addr − 0x80000000).
- R4: When sparse_mode = 1, the same range gives dn_addr[4:0] = offset[4:0], dn_addr[15:5] = offset[22:12], and all higher bits 0. The mode is sampled per request at acceptance, so it can be switched between requests.
- R5: I/O addresses 0x80C00000–0xBF7FFFFF give dn_kind = 0 with dn_addr = cpu_addr − 0x80000000, whatever the mode.
- R6: Addresses 0xC0000000–0xFEFFFFFF give dn_kind = 3 with dn_addr = cpu_addr − 0xC0000000.
- R7: A 1-byte read at 0xBFFFFFF0 gives dn_kind = 2 with dn_addr = 0. A write there does not reach the downstream side and completes on the response channel with rsp_err = 0. A read there of any other size is an error.
- R8: An address outside every window, or a size other than 1, 2 or 4, produces no downstream request. It gives a one-cycle rsp_valid with rsp_err = 1 and rsp_rdata = 0xFFFFFFFF.
- R9: dn_write, dn_size and dn_wdata copy the accepted request unchanged. Data stays in little-endian lane order, and unaligned addresses are accepted without any check.
- R10: Each accepted request gives exactly one of dn_valid or rsp_valid on the next cycle. While dn_valid is 1 and dn_ready is 0, the downstream fields hold steady and cpu_ready is 0.
- R11: One cycle after the inputs are applied, swz_line = (swz_pin + swz_slot) mod 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | CPU request offered |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_addr | input | 32 | CPU byte address |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 3 | Byte count: 1, 2 or 4 |
| cpu_wdata | input | 32 | Write data, little-endian lanes |
| sparse_mode | input | 1 | 1 = sparse I/O mapping, 0 = contiguous |
| dn_valid | output | 1 | Downstream request pending |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_kind | output | 2 | 0 I/O, 1 config, 2 interrupt ack, 3 memory |
| dn_addr | output | 32 | Translated target address |
| dn_write | output | 1 | Copied write flag |
| dn_size | output | 3 | Copied byte count |
| dn_wdata | output | 32 | Copied write data |
| rsp_valid | output | 1 | Local completion (error or dropped write) |
| rsp_err | output | 1 | Completion is an error |
| rsp_rdata | output | 32 | All ones on error, else 0 |
| swz_pin | input | 2 | Interrupt pin index of a device |
| swz_slot | input | 5 | Device slot number |
| swz_line | output | 1 | Controller line after swizzle |

## Verification
The assertions assume that dn_ready is only meaningful while dn_valid is high. They also assume that the CPU side offers a request only when it is prepared to have it taken on the next edge where cpu_ready is high. The stimulus meets both assumptions by driving inputs only on falling edges and by keeping cpu_valid high for exactly one accepting edge. Backpressure is tested by holding dn_ready low across several edges while a second request waits. The mode input is changed only between requests, so the sampling-at-acceptance rule is exercised without changing the mode in the same cycle a request is taken.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic [1:0] {
    HBD_IO   = 2'd0,
    HBD_CFG  = 2'd1,
    HBD_IACK = 2'd2,
    HBD_MEM  = 2'd3
  } hbd_kind_e;

  typedef struct packed {
    logic      fwd;
    logic      err;
    hbd_kind_e kind;
    logic [31:0] taddr;
  } hbd_class_t;
endpackage

// File: rtl/hbd_cfg_devnum.sv
module hbd_cfg_devnum #(
  parameter int SEL_N = 11,
  parameter int DEV_W = $clog2(SEL_N + 1)
) (
  input  logic [SEL_N-1:0] sel,
  output logic [DEV_W-1:0] dev
);
  // lowest set select bit wins; SEL_N when no bit is set
  always_comb begin
    dev = DEV_W'(SEL_N);
    for (int i = SEL_N - 1; i >= 0; i--) begin
      if (sel[i]) dev = DEV_W'(i);
    end
  end
endmodule

// File: rtl/hbd_io_map.sv
module hbd_io_map #(
  parameter int SPARSE_LOG2 = 23,
  parameter int PAGE_LSB    = 12,
  parameter int LOW_W       = 5,
  parameter int PORT_W      = 16
) (
  input  logic [31:0] off,
  input  logic        sparse,
  output logic [31:0] port
);
  localparam logic [32:0] SPARSE_SIZE = 33'(1) << SPARSE_LOG2;
  localparam int          PAGE_W      = SPARSE_LOG2 - PAGE_LSB;
  localparam logic [31:0] PAGE_MASK   = (32'(1) << PAGE_W) - 32'(1);
  localparam logic [31:0] LOW_MASK    = (32'(1) << LOW_W) - 32'(1);
  localparam logic [31:0] PORT_MASK   = (32'(1) << PORT_W) - 32'(1);

  logic        in_low;
  logic [31:0] sparse_port;
  logic [31:0] contig_port;

  assign in_low      = {1'b0, off} < SPARSE_SIZE;
  assign sparse_port = (((off >> PAGE_LSB) & PAGE_MASK) << LOW_W) | (off & LOW_MASK);
  assign contig_port = off & PORT_MASK;

  always_comb begin
    if (!in_low)     port = off;
    else if (sparse) port = sparse_port;
    else             port = contig_port;
  end
endmodule

// File: rtl/hbd_classify.sv
module hbd_classify
  import hbd_pkg::*;
#(
  parameter logic [31:0] IO_BASE     = 32'h8000_0000,
  parameter logic [31:0] IO_SIZE     = 32'h3F80_0000,
  parameter logic [31:0] CFG_BASE    = 32'h8080_0000,
  parameter int          CFG_LOG2    = 22,
  parameter int          CFG_SEL_LSB = 11,
  parameter logic [31:0] MEM_BASE    = 32'hC000_0000,
  parameter logic [31:0] MEM_SIZE    = 32'h3F00_0000,
  parameter logic [31:0] IACK_ADDR   = 32'hBFFF_FFF0,
  parameter int          SPARSE_LOG2 = 23
) (
  input  logic [31:0] addr,
  input  logic        write,
  input  logic [2:0]  size,
  input  logic        sparse,
  output hbd_class_t  cls
);
  localparam int          SEL_N   = CFG_LOG2 - CFG_SEL_LSB;
  localparam int          DEV_W   = $clog2(SEL_N + 1);
  localparam logic [32:0] IO_END  = {1'b0, IO_BASE} + {1'b0, IO_SIZE};
  localparam logic [32:0] MEM_END = {1'b0, MEM_BASE} + {1'b0, MEM_SIZE};
  localparam logic [32:0] CFG_END = {1'b0, CFG_BASE} + (33'(1) << CFG_LOG2);

  logic             size_ok, in_io, in_cfg, in_mem, is_iack;
  logic [31:0]      io_off, mem_off, io_port, cfg_addr;
  logic [DEV_W-1:0] dev;

  assign size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
  assign in_io   = (addr >= IO_BASE)  && ({1'b0, addr} < IO_END);
  assign in_cfg  = (addr >= CFG_BASE) && ({1'b0, addr} < CFG_END);
  assign in_mem  = (addr >= MEM_BASE) && ({1'b0, addr} < MEM_END);
  assign is_iack = (addr == IACK_ADDR);
  assign io_off  = addr - IO_BASE;
  assign mem_off = addr - MEM_BASE;

  hbd_cfg_devnum #(.SEL_N(SEL_N), .DEV_W(DEV_W)) u_devnum (
    .sel (addr[CFG_LOG2-1:CFG_SEL_LSB]),
    .dev (dev)
  );

  assign cfg_addr = 32'({dev, addr[CFG_SEL_LSB-1:0]});

  hbd_io_map #(.SPARSE_LOG2(SPARSE_LOG2)) u_iomap (
    .off    (io_off),
    .sparse (sparse),
    .port   (io_port)
  );

  always_comb begin
    cls = '{fwd: 1'b0, err: 1'b1, kind: HBD_IO, taddr: 32'd0};
    if (!size_ok) begin
      cls.err = 1'b1;
    end else if (is_iack) begin
      if (write) begin
        cls.err = 1'b0;
      end else if (size == 3'd1) begin
        cls.fwd  = 1'b1;
        cls.err  = 1'b0;
        cls.kind = HBD_IACK;
      end
    end else if (in_cfg) begin
      cls.fwd   = 1'b1;
      cls.err   = 1'b0;
      cls.kind  = HBD_CFG;
      cls.taddr = cfg_addr;
    end else if (in_io) begin
      cls.fwd   = 1'b1;
      cls.err   = 1'b0;
      cls.kind  = HBD_IO;
      cls.taddr = io_port;
    end else if (in_mem) begin
      cls.fwd   = 1'b1;
      cls.err   = 1'b0;
      cls.kind  = HBD_MEM;
      cls.taddr = mem_off;
    end
  end
endmodule

// File: rtl/hbd_irq_swizzle.sv
module hbd_irq_swizzle #(
  parameter int PIN_W     = 2,
  parameter int SLOT_W    = 5,
  parameter int NUM_LINES = 2,
  parameter int LINE_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pin,
  input  logic [SLOT_W-1:0] slot,
  output logic [LINE_W-1:0] line
);
  localparam int SUM_W = ((PIN_W > SLOT_W) ? PIN_W : SLOT_W) + 1;

  logic [SUM_W-1:0] sum;
  assign sum = SUM_W'(pin) + SUM_W'(slot);

  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= LINE_W'(sum % SUM_W'(NUM_LINES));
  end
endmodule

// File: rtl/hbd_bridge_decode.sv
module hbd_bridge_decode
  import hbd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int PIN_W  = 2,
  parameter int SLOT_W = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_valid,
  output logic          cpu_ready,
  input  logic [AW-1:0] cpu_addr,
  input  logic          cpu_write,
  input  logic [2:0]    cpu_size,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          sparse_mode,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [1:0]    dn_kind,
  output logic [AW-1:0] dn_addr,
  output logic          dn_write,
  output logic [2:0]    dn_size,
  output logic [DW-1:0] dn_wdata,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  input  logic [PIN_W-1:0]  swz_pin,
  input  logic [SLOT_W-1:0] swz_slot,
  output logic          swz_line
);
  hbd_class_t cls;
  logic       take;

  hbd_classify u_cls (
    .addr   (cpu_addr),
    .write  (cpu_write),
    .size   (cpu_size),
    .sparse (sparse_mode),
    .cls    (cls)
  );

  assign cpu_ready = !dn_valid;
  assign take      = cpu_valid && cpu_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid  <= 1'b0;
      dn_kind   <= 2'd0;
      dn_addr   <= '0;
      dn_write  <= 1'b0;
      dn_size   <= 3'd0;
      dn_wdata  <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (dn_valid && dn_ready) dn_valid <= 1'b0;
      if (take) begin
        if (cls.fwd) begin
          dn_valid <= 1'b1;
          dn_kind  <= cls.kind;
          dn_addr  <= cls.taddr;
          dn_write <= cpu_write;
          dn_size  <= cpu_size;
          dn_wdata <= cpu_wdata;
        end else begin
          rsp_valid <= 1'b1;
          rsp_err   <= cls.err;
          rsp_rdata <= cls.err ? '1 : '0;
        end
      end
    end
  end

  hbd_irq_swizzle #(.PIN_W(PIN_W), .SLOT_W(SLOT_W), .NUM_LINES(2)) u_swz (
    .clk  (clk),
    .rst  (rst),
    .pin  (swz_pin),
    .slot (swz_slot),
    .line (swz_line)
  );

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready) |=> (dn_valid ^ rsp_valid));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_kind)
                                 && $stable(dn_wdata) && $stable(dn_size)));

  assert_rsp_excl_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !dn_valid);

  assert_cfg_range_R2: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_kind == 2'd1) |-> (dn_addr[AW-1:15] == '0));

  assert_iack_form_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && dn_kind == 2'd2) |-> (dn_size == 3'd1 && !dn_write));
endmodule

// File: tb/hbd_bridge_decode_test.sv
`timescale 1ns/1ps
module hbd_bridge_decode_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_valid, cpu_ready, cpu_write, sparse_mode;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [2:0]  cpu_size;
  logic        dn_valid, dn_ready, dn_write;
  logic [1:0]  dn_kind;
  logic [31:0] dn_addr, dn_wdata;
  logic [2:0]  dn_size;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [1:0]  swz_pin;
  logic [4:0]  swz_slot;
  logic        swz_line;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  hbd_bridge_decode uut (
    .clk(clk), .rst(rst),
    .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_addr(cpu_addr),
    .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
    .sparse_mode(sparse_mode),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_kind(dn_kind),
    .dn_addr(dn_addr), .dn_write(dn_write), .dn_size(dn_size), .dn_wdata(dn_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .swz_pin(swz_pin), .swz_slot(swz_slot), .swz_line(swz_line)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // Reference decode written from the requirements.
  task automatic model(input logic [31:0] a, input logic wr, input logic [2:0] sz,
                       input logic sp, output logic fwd, output logic err,
                       output logic [1:0] kind, output logic [31:0] ta);
    logic [31:0] o;
    int dev;
    fwd = 0; err = 1; kind = 0; ta = 0;
    if (!(sz == 1 || sz == 2 || sz == 4)) begin
      err = 1;
    end else if (a == 32'hBFFF_FFF0) begin
      if (wr) err = 0;
      else if (sz == 1) begin fwd = 1; err = 0; kind = 2; end
    end else if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) begin
      dev = 11;
      for (int i = 10; i >= 0; i--) if (a[11+i]) dev = i;
      fwd = 1; err = 0; kind = 1;
      ta = (32'(dev) << 11) | (a & 32'h7FF);
    end else if (a >= 32'h8000_0000 && a <= 32'hBF7F_FFFF) begin
      o = a - 32'h8000_0000;
      fwd = 1; err = 0; kind = 0;
      if (o >= 32'h0080_0000) ta = o;
      else if (sp) ta = (o & 32'h1F) | (((o >> 12) & 32'h7FF) << 5);
      else ta = o & 32'hFFFF;
    end else if (a >= 32'hC000_0000 && a <= 32'hFEFF_FFFF) begin
      fwd = 1; err = 0; kind = 3; ta = a - 32'hC000_0000;
    end
  endtask

  task automatic do_req(input string req, input logic [31:0] a, input logic wr,
                        input logic [2:0] sz, input logic sp, input logic [31:0] wd);
    logic fwd, err;
    logic [1:0] kind;
    logic [31:0] ta;
    model(a, wr, sz, sp, fwd, err, kind, ta);
    @(negedge clk);
    cpu_addr = a; cpu_write = wr; cpu_size = sz; cpu_wdata = wd;
    sparse_mode = sp; cpu_valid = 1;
    @(negedge clk);
    cpu_valid = 0;
    chk(req, "dn_valid", 32'(dn_valid), 32'(fwd));
    chk(req, "rsp_valid", 32'(rsp_valid), 32'(!fwd));
    if (fwd) begin
      chk(req, "dn_kind", 32'(dn_kind), 32'(kind));
      chk(req, "dn_addr", dn_addr, ta);
      chk("R9", "dn_write", 32'(dn_write), 32'(wr));
      chk("R9", "dn_size", 32'(dn_size), 32'(sz));
      chk("R9", "dn_wdata", dn_wdata, wd);
    end else begin
      chk(req, "rsp_err", 32'(rsp_err), 32'(err));
      chk(req, "rsp_rdata", rsp_rdata, err ? 32'hFFFF_FFFF : 32'h0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "cpu_ready", 32'(cpu_ready), 1);
    chk("R1", "dn_valid", 32'(dn_valid), 0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "swz_line", 32'(swz_line), 0);
  endtask

  task automatic t_config;
    for (int i = 0; i < 11; i++)
      do_req("R2", 32'h8080_0000 | (32'h800 << i) | 32'h0000_0123 | (32'h1 << 21), 0, 4, 0, 0);
    do_req("R2", 32'h8080_0004, 1, 4, 0, 32'hDEAD_BEEF);
    do_req("R2", 32'h80BF_FFFF, 0, 1, 1, 0);
    for (int i = 0; i < 11; i++)
      do_req("R2", 32'h8080_0000 | (32'h800 << i), 0, 2, 0, 0);
  endtask

  task automatic t_io;
    do_req("R3", 32'h8000_0000, 0, 1, 0, 0);
    do_req("R3", 32'h8001_2345, 1, 2, 0, 32'h0000_A55A);
    do_req("R3", 32'h807F_FFFF, 0, 1, 0, 0);
    do_req("R4", 32'h807F_FFFF, 0, 1, 1, 0);
    do_req("R4", 32'h8012_3013, 1, 4, 1, 32'h1234_5678);
    do_req("R4", 32'h8000_0CF8, 0, 4, 1, 0);
    do_req("R3", 32'h8000_0CF8, 0, 4, 0, 0);
    do_req("R5", 32'h80C0_0000, 0, 4, 1, 0);
    do_req("R5", 32'h80C0_0000, 0, 4, 0, 0);
    do_req("R5", 32'hBF7F_FFFF, 1, 1, 1, 32'h0000_00AB);
    do_req("R9", 32'h8000_0003, 1, 4, 0, 32'hCAFE_F00D);
  endtask

  task automatic t_mem_iack_err;
    do_req("R6", 32'hC000_0000, 0, 4, 0, 0);
    do_req("R6", 32'hFEFF_FFFF, 1, 1, 0, 32'h0000_0077);
    do_req("R7", 32'hBFFF_FFF0, 0, 1, 0, 0);
    do_req("R7", 32'hBFFF_FFF0, 1, 1, 0, 32'h0000_0055);
    do_req("R7", 32'hBFFF_FFF0, 0, 4, 0, 0);
    do_req("R8", 32'hBF80_0000, 0, 4, 0, 0);
    do_req("R8", 32'hBFFF_FFEF, 0, 1, 0, 0);
    do_req("R8", 32'hFF00_0000, 0, 4, 0, 0);
    do_req("R8", 32'h7FFF_FFFF, 1, 4, 0, 32'h1);
    do_req("R8", 32'h0000_0000, 0, 1, 0, 0);
    do_req("R8", 32'h8000_0000, 0, 3, 0, 0);
    do_req("R8", 32'hC000_0000, 1, 0, 0, 0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    dn_ready = 0;
    cpu_addr = 32'hC000_1000; cpu_write = 1; cpu_size = 4;
    cpu_wdata = 32'h0BAD_CAFE; sparse_mode = 0; cpu_valid = 1;
    @(negedge clk);
    cpu_addr = 32'hC000_2000; cpu_wdata = 32'h1111_2222;
    for (int k = 0; k < 3; k++) begin
      chk("R10", "dn_valid held", 32'(dn_valid), 1);
      chk("R10", "cpu_ready low", 32'(cpu_ready), 0);
      chk("R10", "dn_addr held", dn_addr, 32'h0000_1000);
      @(negedge clk);
    end
    dn_ready = 1;
    @(negedge clk);
    chk("R10", "drained", 32'(dn_valid), 0);
    @(negedge clk);
    cpu_valid = 0;
    chk("R10", "second taken", 32'(dn_valid), 1);
    chk("R10", "second addr", dn_addr, 32'h0000_2000);
    chk("R10", "second data", dn_wdata, 32'h1111_2222);
    @(negedge clk);
  endtask

  task automatic t_swizzle;
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 32; s++) begin
        @(negedge clk);
        swz_pin = 2'(p); swz_slot = 5'(s);
        @(negedge clk);
        chk("R11", "swz_line", 32'(swz_line), 32'((p + s) % 2));
      end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1; cpu_valid = 0; cpu_addr = 0; cpu_write = 0; cpu_size = 1;
    cpu_wdata = 0; sparse_mode = 0; dn_ready = 1; swz_pin = 0; swz_slot = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_config();
    t_io();
    t_mem_iack_err();
    t_backpressure();
    t_swizzle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule